// File: doc/BRIEF.md
# SPI FIFO Transfer Sequencer

This block is the per-channel control engine of an SPI controller. It decides when a word moves between the channel's transmit and receive storage and the serial shift engine. The storage is either the single holding registers or the shared FIFOs. The sequencer raises pop and push strobes toward the FIFOs and a start strobe toward the shifter, then waits for the shifter's done pulse. It keeps the channel's transfer status flags up to date. When both FIFOs are enabled, it also counts words down from a programmed 16-bit value and raises an end-of-count event when that value runs out.

The transfer mode, the turbo bit, the word length field and the two FIFO enables come from the channel configuration. The host-side register logic reports a write to the TX holding register or TX FIFO on `tx_wr_i` and a read of the RX holding register on `rx_rd_i`. The FIFOs report their levels and full and empty flags. The sequencer handles one word per pass through its state machine and checks its start condition again in the idle state before each new word.

Top module: `spi_xfer_seq`

## Requirements
- R1: While `chan_en_i` is low, no pop, shift start or push is issued.
- R2: The transfer mode on `xfer_mode_i` is encoded as 0 full duplex, 1 receive-only, 2 transmit-only, and 3 behaves as full duplex. A word is held back while RX storage is full unless the mode is transmit-only. Without the RX FIFO, "full" means status bit 0, and turbo overrides it. With the RX FIFO, it means the FIFO full flag, and turbo does not override it.
- R3: A word is held back while TX storage is empty unless the mode is receive-only. Without the TX FIFO, "empty" means status bit 1. With the TX FIFO, it means a FIFO level of zero.
- R4: `word_len_o` equals `wl_field_i` plus one. `wl_bad_o` is high exactly when the field is below 3.
- R5: With only the TX FIFO enabled, each word is a pop followed by a shift start on the next cycle. A word starts only when the TX FIFO level is at least `tx_start_lvl_i` and nonzero.
- R6: With only the RX FIFO enabled, each word is a shift start, the shifter's done pulse, and then a push on the cycle after done.
- R7: With both FIFOs enabled, the sequencer repeats pop, shift and push while the RX FIFO is not full, the TX FIFO is not empty and the remaining count is nonzero. The count decrements by one per completed word.
- R8: `status_o` bit 0 is RX full, bit 1 TX empty, bit 2 end of transfer, bit 3 TX FIFO empty, bit 4 TX FIFO full, bit 5 RX FIFO empty and bit 6 RX FIFO full. Bits 3 and 4 read zero unless the TX FIFO is enabled, and bits 5 and 6 read zero unless the RX FIFO is enabled.
- R9: When a word completes, bits 1 and 2 are set, and bit 0 is set unless the mode is transmit-only. `tx_wr_i` clears bits 1 and 2, and `rx_rd_i` clears bit 0. Completion takes priority over a clear in the same cycle.
- R10: `eow_o` pulses for one cycle, on the cycle after the word that takes the count from 1 to 0. With both FIFOs enabled, a count of zero blocks transfers. `cnt_load_i` loads `cnt_val_i` into the count.
- R11: After reset, `status_o` is 0x02 with both FIFOs disabled, the count is zero and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable |
| xfer_mode_i | input | 2 | Transfer mode: 0 duplex, 1 receive-only, 2 transmit-only |
| turbo_i | input | 1 | Lets words start while the RX holding register is full |
| wl_field_i | input | WL_W | Word length field (length minus one) |
| tx_fifo_en_i | input | 1 | TX FIFO enabled for this channel |
| rx_fifo_en_i | input | 1 | RX FIFO enabled for this channel |
| tx_lvl_i | input | LVL_W | TX FIFO fill level |
| tx_start_lvl_i | input | LVL_W | TX FIFO level needed to start a word (TX-FIFO-only mode) |
| tx_fifo_full_i | input | 1 | TX FIFO full flag |
| rx_fifo_empty_i | input | 1 | RX FIFO empty flag |
| rx_fifo_full_i | input | 1 | RX FIFO full flag |
| tx_wr_i | input | 1 | Host wrote transmit data |
| rx_rd_i | input | 1 | Host read the RX holding register |
| cnt_load_i | input | 1 | Load the word count |
| cnt_val_i | input | CNT_W | Word count value to load |
| shift_done_i | input | 1 | Shifter finished the current word |
| tx_pop_o | output | 1 | Pop one word from the TX FIFO |
| rx_push_o | output | 1 | Push the received word into the RX FIFO |
| shift_start_o | output | 1 | Start the shifter on one word |
| word_len_o | output | WL_W+1 | Word length in bits |
| wl_bad_o | output | 1 | Word length field is invalid |
| status_o | output | 7 | Channel status flags |
| cnt_o | output | CNT_W | Remaining word count |
| eow_o | output | 1 | End-of-count event pulse |

## Verification
The hardest situation to reach is the dual-FIFO loop stopping on one condition while the other two still allow transfers. The cases are the count running out while TX data remains, and the RX FIFO filling while the count is still nonzero. The bench keeps a behavioural FIFO model whose levels it can preset while the channel is disabled. It loads a count smaller than the preset TX level and expects exactly that many pop-shift-push triples, with the end-of-count pulse on the last one. It then reloads a larger count with only one free RX slot, so the loop must stop after one word with no event.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    XM_DUPLEX  = 2'd0,
    XM_RX_ONLY = 2'd1,
    XM_TX_ONLY = 2'd2,
    XM_RSVD    = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_POP   = 3'd1,
    ST_START = 3'd2,
    ST_WAIT  = 3'd3,
    ST_PUSH  = 3'd4
  } seq_state_e;

  localparam int STAT_W = 7;

endpackage

// File: rtl/spi_seq_gate.sv
module spi_seq_gate
  import spi_seq_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             turbo_i,
  input  logic             tx_fifo_en_i,
  input  logic             rx_fifo_en_i,
  input  logic             hold_rx_full_i,
  input  logic             hold_tx_empty_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] start_lvl_i,
  input  logic             rx_fifo_full_i,
  input  logic             cnt_zero_i,
  output logic             go_o,
  output logic             pop_req_o,
  output logic             push_req_o,
  output logic             cnt_en_o
);

  logic rx_used, tx_used, dual, tx_short, rx_block, tx_block;

  always_comb begin
    rx_used  = (mode_i != XM_TX_ONLY);
    tx_used  = (mode_i != XM_RX_ONLY);
    dual     = tx_fifo_en_i && rx_fifo_en_i;
    // start level only gates the TX-FIFO-only mode
    tx_short = (tx_lvl_i == '0) || (!rx_fifo_en_i && (tx_lvl_i < start_lvl_i));
    rx_block = rx_used && (rx_fifo_en_i ? rx_fifo_full_i : (hold_rx_full_i && !turbo_i));
    tx_block = tx_used && (tx_fifo_en_i ? tx_short : hold_tx_empty_i);
    go_o       = en_i && !rx_block && !tx_block && !(dual && cnt_zero_i);
    pop_req_o  = tx_used && tx_fifo_en_i;
    push_req_o = rx_used && rx_fifo_en_i;
    cnt_en_o   = dual;
  end

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
  import spi_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       pop_req_i,
  input  logic       push_req_i,
  input  logic       shift_done_i,
  output logic       tx_pop_o,
  output logic       shift_start_o,
  output logic       rx_push_o,
  output logic       word_done_o,
  output seq_state_e state_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go_i) state_d = pop_req_i ? ST_POP : ST_START;
      ST_POP:   state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (shift_done_i) state_d = push_req_i ? ST_PUSH : ST_IDLE;
      ST_PUSH:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign tx_pop_o      = (state_q == ST_POP);
  assign shift_start_o = (state_q == ST_START);
  assign rx_push_o     = (state_q == ST_PUSH);
  assign word_done_o   = (state_q == ST_WAIT) && shift_done_i;
  assign state_o       = state_q;

endmodule

// File: rtl/spi_seq_wcnt.sv
module spi_seq_wcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             eow_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             eow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      eow_q <= 1'b0;
    end else begin
      if (load_i)                     cnt_q <= val_i;
      else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - ONE;
      eow_q <= !load_i && dec_i && (cnt_q == ONE);
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign eow_o  = eow_q;

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 7,
  parameter int WL_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_en_i,
  input  logic [1:0]       xfer_mode_i,
  input  logic             turbo_i,
  input  logic [WL_W-1:0]  wl_field_i,
  input  logic             tx_fifo_en_i,
  input  logic             rx_fifo_en_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] tx_start_lvl_i,
  input  logic             tx_fifo_full_i,
  input  logic             rx_fifo_empty_i,
  input  logic             rx_fifo_full_i,
  input  logic             tx_wr_i,
  input  logic             rx_rd_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             shift_done_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic             shift_start_o,
  output logic [WL_W:0]    word_len_o,
  output logic             wl_bad_o,
  output logic [STAT_W-1:0] status_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eow_o
);

  localparam int             LEN_W  = WL_W + 1;
  localparam logic [WL_W-1:0] WL_MIN = WL_W'(3);

  logic       go, pop_req, push_req, cnt_en, cnt_zero, word_done;
  logic       rx_full_q, tx_empty_q, eot_q;
  seq_state_e state;

  spi_seq_gate #(.LVL_W(LVL_W)) i_gate (
    .en_i            (chan_en_i),
    .mode_i          (xfer_mode_i),
    .turbo_i         (turbo_i),
    .tx_fifo_en_i    (tx_fifo_en_i),
    .rx_fifo_en_i    (rx_fifo_en_i),
    .hold_rx_full_i  (rx_full_q),
    .hold_tx_empty_i (tx_empty_q),
    .tx_lvl_i        (tx_lvl_i),
    .start_lvl_i     (tx_start_lvl_i),
    .rx_fifo_full_i  (rx_fifo_full_i),
    .cnt_zero_i      (cnt_zero),
    .go_o            (go),
    .pop_req_o       (pop_req),
    .push_req_o      (push_req),
    .cnt_en_o        (cnt_en)
  );

  spi_seq_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .go_i          (go),
    .pop_req_i     (pop_req),
    .push_req_i    (push_req),
    .shift_done_i  (shift_done_i),
    .tx_pop_o      (tx_pop_o),
    .shift_start_o (shift_start_o),
    .rx_push_o     (rx_push_o),
    .word_done_o   (word_done),
    .state_o       (state)
  );

  spi_seq_wcnt #(.CNT_W(CNT_W)) i_wcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load_i),
    .val_i  (cnt_val_i),
    .dec_i  (word_done && cnt_en),
    .cnt_o  (cnt_o),
    .zero_o (cnt_zero),
    .eow_o  (eow_o)
  );

  // completion wins over host-side clears in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_q  <= 1'b0;
      tx_empty_q <= 1'b1;
      eot_q      <= 1'b0;
    end else if (word_done) begin
      eot_q      <= 1'b1;
      tx_empty_q <= 1'b1;
      if (xfer_mode_i != XM_TX_ONLY) rx_full_q <= 1'b1;
    end else begin
      if (tx_wr_i) begin
        tx_empty_q <= 1'b0;
        eot_q      <= 1'b0;
      end
      if (rx_rd_i) rx_full_q <= 1'b0;
    end
  end

  assign status_o = {rx_fifo_en_i & rx_fifo_full_i,
                     rx_fifo_en_i & rx_fifo_empty_i,
                     tx_fifo_en_i & tx_fifo_full_i,
                     tx_fifo_en_i & (tx_lvl_i == '0),
                     eot_q, tx_empty_q, rx_full_q};

  assign word_len_o = LEN_W'(wl_field_i) + LEN_W'(1);
  assign wl_bad_o   = (wl_field_i < WL_MIN);

endmodule

// File: rtl/spi_xfer_seq_chk.sv
module spi_xfer_seq_chk
  import spi_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chan_en_i,
  input logic             shift_done_i,
  input logic             tx_pop_o,
  input logic             shift_start_o,
  input logic             rx_push_o,
  input logic [6:0]       status_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             eow_o,
  input seq_state_e       state_i
);

  // R1
  start_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE && $past(state_i) == ST_IDLE) |-> $past(chan_en_i));

  // R5
  pop_then_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |=> shift_start_o);

  // R6
  push_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> $past(shift_done_i));

  // R7
  strobes_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_pop_o, shift_start_o, rx_push_o}));

  // R9
  eot_after_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT && shift_done_i) |=> (status_o[2] && status_o[1]));

  // R10
  eow_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eow_o |-> (cnt_o == '0));

endmodule

bind spi_xfer_seq spi_xfer_seq_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .chan_en_i     (chan_en_i),
  .shift_done_i  (shift_done_i),
  .tx_pop_o      (tx_pop_o),
  .shift_start_o (shift_start_o),
  .rx_push_o     (rx_push_o),
  .status_o      (status_o),
  .cnt_o         (cnt_o),
  .eow_o         (eow_o),
  .state_i       (state)
);

// File: tb/test_spi_xfer_seq.sv
`timescale 1ns/1ps
module test_spi_xfer_seq;

  localparam int CNT_W    = 16;
  localparam int LVL_W    = 7;
  localparam int WL_W     = 5;
  localparam int RX_DEPTH = 4;
  localparam int TX_DEPTH = 64;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic chan_en_i = 1'b0;
  logic [1:0] xfer_mode_i = 2'd0;
  logic turbo_i = 1'b0;
  logic [WL_W-1:0] wl_field_i = 5'd7;
  logic tx_fifo_en_i = 1'b0;
  logic rx_fifo_en_i = 1'b0;
  logic [LVL_W-1:0] tx_lvl_i;
  logic [LVL_W-1:0] tx_start_lvl_i = '0;
  logic tx_fifo_full_i, rx_fifo_empty_i, rx_fifo_full_i;
  logic tx_wr_i = 1'b0;
  logic rx_rd_i = 1'b0;
  logic cnt_load_i = 1'b0;
  logic [CNT_W-1:0] cnt_val_i = '0;
  logic shift_done_i = 1'b0;
  logic tx_pop_o, rx_push_o, shift_start_o, wl_bad_o, eow_o;
  logic [WL_W:0] word_len_o;
  logic [6:0] status_o;
  logic [CNT_W-1:0] cnt_o;

  always #2 clk_i = ~clk_i;

  // FIFO model: bases are set by the stimulus, deltas by the monitor
  int tx_base = 0, rx_base = 0, pops = 0, pushes = 0, sh_cnt = 0;
  int tx_lvl, rx_cnt;
  assign tx_lvl          = tx_base - pops;
  assign rx_cnt          = rx_base + pushes;
  assign tx_lvl_i        = LVL_W'(tx_lvl);
  assign tx_fifo_full_i  = (tx_lvl >= TX_DEPTH);
  assign rx_fifo_empty_i = (rx_cnt == 0);
  assign rx_fifo_full_i  = (rx_cnt >= RX_DEPTH);

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  byte   exp_q[$];
  string req_q[$];
  string cur_req = "R11";

  spi_xfer_seq #(.CNT_W(CNT_W), .LVL_W(LVL_W), .WL_W(WL_W)) i_spi_xfer_seq (
    .clk_i, .rst_ni, .chan_en_i, .xfer_mode_i, .turbo_i, .wl_field_i,
    .tx_fifo_en_i, .rx_fifo_en_i, .tx_lvl_i, .tx_start_lvl_i, .tx_fifo_full_i,
    .rx_fifo_empty_i, .rx_fifo_full_i, .tx_wr_i, .rx_rd_i, .cnt_load_i,
    .cnt_val_i, .shift_done_i, .tx_pop_o, .rx_push_o, .shift_start_o,
    .word_len_o, .wl_bad_o, .status_o, .cnt_o, .eow_o
  );

  task automatic mon_item(input byte code);
    mon_chk++;
    if (exp_q.size() == 0) begin
      mon_fail++;
      $display("FAIL %s strobe: actual %c expected none", cur_req, code);
    end else begin
      byte   e = exp_q.pop_front();
      string r = req_q.pop_front();
      if (e != code) begin
        mon_fail++;
        $display("FAIL %s strobe: actual %c expected %c", r, code, e);
      end
    end
  endtask

  // monitor + shifter + FIFO model, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (tx_pop_o)      mon_item("P");
      if (shift_start_o) mon_item("S");
      if (rx_push_o)     mon_item("U");
      if (eow_o)         mon_item("E");
      if (tx_pop_o)  pops++;
      if (rx_push_o) pushes++;
    end
    if (sh_cnt != 0) sh_cnt--;
    if (shift_start_o) sh_cnt = 3;
    shift_done_i = (sh_cnt == 1);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic expect_seq(input string req, input string seq);
    cur_req = req;
    for (int i = 0; i < seq.len(); i++) begin
      exp_q.push_back(seq[i]);
      req_q.push_back(req);
    end
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_drained(input string req);
    chk(req, "pending strobes", exp_q.size(), 0);
  endtask

  task automatic pulse_tx_wr();
    tx_wr_i = 1'b1; step(1); tx_wr_i = 1'b0;
  endtask

  task automatic pulse_rx_rd();
    rx_rd_i = 1'b1; step(1); rx_rd_i = 1'b0;
  endtask

  task automatic load_cnt(input int v);
    cnt_val_i = CNT_W'(v); cnt_load_i = 1'b1; step(1); cnt_load_i = 1'b0;
  endtask

  task automatic set_tx(input int v); tx_base = v + pops;    endtask
  task automatic set_rx(input int v); rx_base = v - pushes;  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R11 reset state
    chk("R11", "status", status_o, 7'h02);
    chk("R11", "count", cnt_o, 0);
    chk("R11", "strobes", {tx_pop_o, shift_start_o, rx_push_o, eow_o}, 0);

    // R1 disabled channel: host write clears flags, nothing moves
    cur_req = "R1";
    pulse_tx_wr();
    step(10);
    chk("R1", "status while disabled", status_o, 7'h00);
    chk_drained("R1");

    // R9 holding-register duplex word
    expect_seq("R9", "S");
    chan_en_i = 1'b1;
    step(20);
    chk("R9", "status after word", status_o, 7'h07);
    chk_drained("R9");

    // R2 RX full blocks, turbo overrides
    cur_req = "R2";
    pulse_tx_wr();
    step(10);
    chk("R2", "status while rx full", status_o, 7'h01);
    expect_seq("R2", "S");
    turbo_i = 1'b1;
    step(20);
    chk("R2", "status after turbo word", status_o, 7'h07);
    chk_drained("R2");
    turbo_i = 1'b0;

    // R3 TX empty blocks, receive-only ignores it
    cur_req = "R3";
    pulse_rx_rd();
    step(10);
    chk("R3", "status while tx empty", status_o, 7'h06);
    expect_seq("R3", "S");
    xfer_mode_i = 2'd1;
    step(20);
    chk("R3", "status after rx-only word", status_o, 7'h07);
    chk_drained("R3");

    // R9 transmit-only never sets RX full
    chan_en_i = 1'b0;
    xfer_mode_i = 2'd2;
    pulse_rx_rd();
    chan_en_i = 1'b1;
    cur_req = "R3";
    step(10);
    chk("R3", "tx-only still waits for data", status_o, 7'h06);
    expect_seq("R9", "S");
    pulse_tx_wr();
    step(20);
    chk("R9", "status after tx-only word", status_o, 7'h06);
    chk_drained("R9");

    // R4 word length
    wl_field_i = 5'd7;  step(1);
    chk("R4", "len 7", {wl_bad_o, word_len_o}, {1'b0, 6'd8});
    wl_field_i = 5'd2;  step(1);
    chk("R4", "len 2", {wl_bad_o, word_len_o}, {1'b1, 6'd3});
    wl_field_i = 5'd3;  step(1);
    chk("R4", "len 3", {wl_bad_o, word_len_o}, {1'b0, 6'd4});
    wl_field_i = 5'd31; step(1);
    chk("R4", "len 31", {wl_bad_o, word_len_o}, {1'b0, 6'd32});
    wl_field_i = 5'd7;

    // R5 TX-FIFO-only with start level
    chan_en_i = 1'b0;
    tx_fifo_en_i = 1'b1;
    tx_start_lvl_i = 7'd3;
    set_tx(2);
    chan_en_i = 1'b1;
    cur_req = "R5";
    step(10);
    chk("R5", "below start level", status_o, 7'h06);
    expect_seq("R5", "PS");
    set_tx(3);
    step(20);
    chk("R5", "tx level after one word", tx_lvl, 2);
    chk_drained("R5");
    expect_seq("R5", "PSPS");
    tx_start_lvl_i = 7'd1;
    step(30);
    chk("R5", "tx level drained", tx_lvl, 0);
    chk("R8", "tx fifo empty flag", status_o, 7'h0E);
    chk_drained("R5");
    chan_en_i = 1'b0;
    set_tx(64);
    step(1);
    chk("R8", "tx fifo full flag", status_o, 7'h16);
    set_tx(0);
    step(1);

    // R6 RX-FIFO-only, receive-only mode, fills the FIFO
    tx_fifo_en_i = 1'b0;
    rx_fifo_en_i = 1'b1;
    xfer_mode_i = 2'd1;
    set_rx(0);
    step(1);
    chk("R8", "rx fifo empty flag", status_o, 7'h26);
    expect_seq("R6", "SUSUSUSU");
    chan_en_i = 1'b1;
    step(40);
    chk("R6", "rx fifo level", rx_cnt, RX_DEPTH);
    chk("R8", "rx fifo full flag", status_o, 7'h47);
    chk_drained("R6");

    // R7 / R10 both FIFOs, count runs out first
    chan_en_i = 1'b0;
    tx_fifo_en_i = 1'b1;
    xfer_mode_i = 2'd0;
    set_tx(5);
    set_rx(0);
    load_cnt(3);
    chk("R10", "count loaded", cnt_o, 3);
    expect_seq("R7", "PSUPSUPSUE");
    chan_en_i = 1'b1;
    step(60);
    chk("R7", "tx level", tx_lvl, 2);
    chk("R7", "rx level", rx_cnt, 3);
    chk("R10", "count exhausted", cnt_o, 0);
    chk("R7", "status", status_o, 7'h07);
    chk_drained("R10");

    // R10 zero count blocks
    cur_req = "R10";
    step(10);
    chk("R10", "tx untouched at zero count", tx_lvl, 2);

    // R7 RX space runs out first, no event
    expect_seq("R7", "PSU");
    load_cnt(5);
    step(30);
    chk("R7", "count after rx full stop", cnt_o, 4);
    chk("R7", "tx level after rx full stop", tx_lvl, 1);
    chk_drained("R7");

    // R10 count of one
    chan_en_i = 1'b0;
    set_rx(0);
    load_cnt(1);
    expect_seq("R10", "PSUE");
    chan_en_i = 1'b1;
    step(30);
    chk("R10", "count after single word", cnt_o, 0);
    chk("R10", "tx level after single word", tx_lvl, 0);
    chk_drained("R10");

    summary();
    $finish;
  end

endmodule